// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the hardware side of one channel's transmit descriptor ring. The ring lives in an internal descriptor RAM. Software fills slots there and hands each one over by setting its ready bit. Every descriptor is 64 bits wide. From the most significant end, it holds a 16-bit status/control word, a 16-bit byte count and a 32-bit buffer address. After a poll request, the engine reads the slot at its pointer. If the slot is ready, the engine sends the byte count as a byte stream with a valid/ready handshake. It then writes the status word back with the ready bit cleared and moves to the next slot. It keeps going this way until it meets a slot that is not ready.

Fetching data from memory is not part of this block. The bytes are a counter pattern seeded from the low byte of the buffer address. The engine reports two events to an interrupt collector, each tagged with the channel number: a transfer-done event for descriptors that request one, and an underrun event when a frame stalls.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset the engine drives no stream byte, no event and no RAM access, and it holds the transmit enable and the poll request clear.
- R2: A descriptor is sent only when all three hold: status bit 15 (ready) is set, transmit enable has been set by `en_set_i`, and a poll is pending. Byte k of a descriptor (k = 0 to count-1) equals buffer address bits 7:0 plus k, modulo 256. Exactly the count in bits 47:32 of the descriptor is sent.
- R3: When a descriptor has been sent, its status word is written back with bit 15 cleared. Every other status bit is unchanged, including wrap, interrupt, last, CRC, software-use and pad.
- R4: The slot pointer starts at slot 0. The RAM address of slot s is CHAN_ID·2·NDESC + s. After a descriptor with status bit 13 (wrap) set, the pointer returns to slot 0. It also returns to slot 0 after slot NDESC-1. Otherwise it moves to the next slot.
- R5: After releasing a descriptor, the engine checks the next slot without needing a new poll.
- R6: The pending poll clears itself when the engine finds a slot whose ready bit is clear. A slot made ready after that is not sent until the next `poll_i` pulse.
- R7: `tx_last_o` is high only on the final byte of a descriptor whose status bit 11 (last in frame) is set.
- R8: Releasing a descriptor with status bit 12 (interrupt) set gives a one-cycle event with code 2'b01 and `evt_chan_o` equal to CHAN_ID. Releasing a descriptor with bit 12 clear gives no event.
- R9: A frame is open when the last released descriptor had bit 11 clear. If the engine finds a not-ready slot while a frame is open, it gives one event with code 2'b10 and stops until the next poll. The open frame is closed, so a later poll that meets the same not-ready slot gives no further underrun event.
- R10: A ready descriptor with a byte count of zero sends no bytes but is still released and still raises its transfer-done event.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the data byte and the last flag hold steady.
- R12: A pulse on `chan_reset_i` aborts any transfer in progress, clears the transmit enable and the pending poll, and reloads the pointer to slot 0. After it, nothing is sent until both an enable pulse and a poll pulse have arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_i | input | 1 | Poll request pulse |
| en_set_i | input | 1 | Sets the transmit enable |
| chan_reset_i | input | 1 | Channel reset pulse |
| ram_re_o | output | 1 | Descriptor read strobe, data returned one cycle later |
| ram_we_o | output | 1 | Status word write strobe |
| ram_addr_o | output | ADDR_W | Descriptor RAM address |
| ram_rdata_i | input | 64 | Descriptor read data {status, count, address} |
| ram_wdata_o | output | 16 | Status word written back |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | End of frame on this byte |
| evt_valid_o | output | 1 | Event pulse |
| evt_code_o | output | 2 | 01 transfer done, 10 underrun |
| evt_chan_o | output | CHAN_W | Channel number of the event |

## Verification
Four properties are checked on every cycle by assertions:
- each write-back clears the ready bit (R3);
- RAM addresses stay inside the channel's slot window (R4);
- bytes hold steady under backpressure (R11);
- events carry the right channel tag (R8).

Assertions also check that a channel reset leaves the stream and the RAM port quiet on the next cycle (R12). Other behaviours only show up over whole transfers, so only the bench scenarios can show them:
- the exact byte pattern;
- which status bits survive the write-back;
- the slot order around both kinds of wrap;
- the poll self-clear;
- single underrun reporting;
- zero-length release;
- the need for both enable and poll after a channel reset.

The bench finishes with a sweep over all eight slots, each with a different length.

// File: rtl/txd_pkg.sv
package txd_pkg;

   // Status word bit positions (behavioural: the engine decodes these)
   localparam int ST_RDY  = 15;
   localparam int ST_WRAP = 13;
   localparam int ST_IRQ  = 12;
   localparam int ST_EOF  = 11;

   typedef struct packed {
      logic [15:0] status;
      logic [15:0] count;
      logic [31:0] bufaddr;
   } desc_t;

   typedef enum logic [1:0] {
      EVT_NONE = 2'b00,
      EVT_DONE = 2'b01,
      EVT_UNDR = 2'b10
   } evt_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_CHECK,
      S_SEND,
      S_RELEASE
   } fsm_e;

endpackage

// File: rtl/txd_ptr.sv
module txd_ptr #(
   parameter int NDESC     = 8,
   parameter int ADDR_W    = 10,
   parameter int RING_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;

   generate
      if ((2 ** IDX_W) == NDESC) begin : g_pow2
         // natural roll-over of the index covers the last slot
         assign idx_nxt = wrap_i ? '0 : idx_q + 1'b1;
      end else begin : g_cmp
         assign idx_nxt = (wrap_i || idx_q == IDX_W'(NDESC - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (adv_i) begin
         idx_q <= idx_nxt;
      end
   end

   assign addr_o = ADDR_W'(RING_BASE) + ADDR_W'(idx_q);

endmodule

// File: rtl/txd_byte_gen.sv
module txd_byte_gen #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [7:0]       seed_i,
   input  logic             eof_i,
   input  logic             tx_ready_i,
   output logic             tx_valid_o,
   output logic [7:0]       tx_data_o,
   output logic             tx_last_o,
   output logic             done_o
);
   logic             active_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [7:0]       seed_q;
   logic             eof_q;
   logic             final_beat;

   assign final_beat = (cnt_q == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         len_q    <= '0;
         seed_q   <= '0;
         eof_q    <= 1'b0;
      end else if (clr_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         len_q    <= len_i;
         seed_q   <= seed_i;
         eof_q    <= eof_i;
      end else if (active_q && tx_ready_i) begin
         if (final_beat) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tx_valid_o = active_q;
   assign tx_data_o  = seed_q + cnt_q[7:0];
   assign tx_last_o  = active_q && eof_q && final_beat;
   assign done_o     = active_q && tx_ready_i && final_beat;

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
   import txd_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll_i,
   input  logic             en_set_i,
   input  logic             chan_reset_i,
   input  logic [63:0]      rdata_i,
   input  logic             gen_done_i,
   output logic             ram_re_o,
   output logic             ram_we_o,
   output logic [15:0]      wdata_o,
   output logic             gen_load_o,
   output logic [LEN_W-1:0] gen_len_o,
   output logic [7:0]       gen_seed_o,
   output logic             gen_eof_o,
   output logic             ptr_adv_o,
   output logic             ptr_wrap_o,
   output logic             evt_valid_o,
   output logic [1:0]       evt_code_o
);
   fsm_e        state_q;
   logic        en_q;
   logic        poll_q;
   logic        open_frame_q;
   logic [15:0] status_q;
   desc_t       rd;
   logic        rdy;
   logic        zero_len;
   logic        unused_ok;

   assign rd       = desc_t'(rdata_i);
   assign rdy      = rd.status[ST_RDY];
   assign zero_len = (rd.count[LEN_W-1:0] == '0);
   assign unused_ok = ^{rd.bufaddr[31:8], rd.count};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         en_q         <= 1'b0;
         poll_q       <= 1'b0;
         open_frame_q <= 1'b0;
         status_q     <= '0;
      end else if (chan_reset_i) begin
         state_q      <= S_IDLE;
         en_q         <= 1'b0;
         poll_q       <= 1'b0;
         open_frame_q <= 1'b0;
      end else begin
         if (en_set_i) begin
            en_q <= 1'b1;
         end
         if (poll_i) begin
            poll_q <= 1'b1;
         end else if (state_q == S_CHECK && !rdy) begin
            poll_q <= 1'b0;
         end
         unique case (state_q)
            S_IDLE: begin
               if (en_q && poll_q) state_q <= S_FETCH;
            end
            S_FETCH: begin
               state_q <= S_CHECK;
            end
            S_CHECK: begin
               if (rdy) begin
                  status_q <= rd.status;
                  state_q  <= zero_len ? S_RELEASE : S_SEND;
               end else begin
                  open_frame_q <= 1'b0;
                  state_q      <= S_IDLE;
               end
            end
            S_SEND: begin
               if (gen_done_i) state_q <= S_RELEASE;
            end
            S_RELEASE: begin
               open_frame_q <= !status_q[ST_EOF];
               state_q      <= S_FETCH;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign ram_re_o   = (state_q == S_FETCH);
   assign ram_we_o   = (state_q == S_RELEASE);
   assign wdata_o    = status_q & ~(16'h1 << ST_RDY);
   assign gen_load_o = (state_q == S_CHECK) && rdy && !zero_len;
   assign gen_len_o  = rd.count[LEN_W-1:0];
   assign gen_seed_o = rd.bufaddr[7:0];
   assign gen_eof_o  = rd.status[ST_EOF];
   assign ptr_adv_o  = (state_q == S_RELEASE);
   assign ptr_wrap_o = status_q[ST_WRAP];

   always_comb begin
      evt_valid_o = 1'b0;
      evt_code_o  = EVT_NONE;
      if (state_q == S_RELEASE && status_q[ST_IRQ]) begin
         evt_valid_o = 1'b1;
         evt_code_o  = EVT_DONE;
      end else if (state_q == S_CHECK && !rdy && open_frame_q) begin
         evt_valid_o = 1'b1;
         evt_code_o  = EVT_UNDR;
      end
   end

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
   import txd_pkg::*;
#(
   parameter int NDESC   = 8,
   parameter int CHAN_ID = 5,
   parameter int CHAN_W  = 6,
   parameter int ADDR_W  = 10,
   parameter int LEN_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_i,
   input  logic              en_set_i,
   input  logic              chan_reset_i,
   output logic              ram_re_o,
   output logic              ram_we_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   input  logic [63:0]       ram_rdata_i,
   output logic [15:0]       ram_wdata_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic [7:0]        tx_data_o,
   output logic              tx_last_o,
   output logic              evt_valid_o,
   output logic [1:0]        evt_code_o,
   output logic [CHAN_W-1:0] evt_chan_o
);
   // transmit slots of a channel, then its receive slots of equal count
   localparam int RING_BASE = CHAN_ID * 2 * NDESC;

   generate
      if (NDESC < 2) begin : g_bad_ndesc
         $error("NDESC must be at least 2");
      end
      if (CHAN_ID >= (2 ** CHAN_W)) begin : g_bad_chan
         $error("CHAN_ID does not fit in CHAN_W bits");
      end
      if (RING_BASE + 2 * NDESC > (2 ** ADDR_W)) begin : g_bad_addr
         $error("ring does not fit in ADDR_W address bits");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must be 1 to 16");
      end
   endgenerate

   logic             gen_load;
   logic [LEN_W-1:0] gen_len;
   logic [7:0]       gen_seed;
   logic             gen_eof;
   logic             gen_done;
   logic             ptr_adv;
   logic             ptr_wrap;

   txd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .poll_i       (poll_i),
      .en_set_i     (en_set_i),
      .chan_reset_i (chan_reset_i),
      .rdata_i      (ram_rdata_i),
      .gen_done_i   (gen_done),
      .ram_re_o     (ram_re_o),
      .ram_we_o     (ram_we_o),
      .wdata_o      (ram_wdata_o),
      .gen_load_o   (gen_load),
      .gen_len_o    (gen_len),
      .gen_seed_o   (gen_seed),
      .gen_eof_o    (gen_eof),
      .ptr_adv_o    (ptr_adv),
      .ptr_wrap_o   (ptr_wrap),
      .evt_valid_o  (evt_valid_o),
      .evt_code_o   (evt_code_o)
   );

   txd_ptr #(.NDESC(NDESC), .ADDR_W(ADDR_W), .RING_BASE(RING_BASE)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (chan_reset_i),
      .adv_i  (ptr_adv),
      .wrap_i (ptr_wrap),
      .addr_o (ram_addr_o)
   );

   txd_byte_gen #(.LEN_W(LEN_W)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (chan_reset_i),
      .load_i     (gen_load),
      .len_i      (gen_len),
      .seed_i     (gen_seed),
      .eof_i      (gen_eof),
      .tx_ready_i (tx_ready_i),
      .tx_valid_o (tx_valid_o),
      .tx_data_o  (tx_data_o),
      .tx_last_o  (tx_last_o),
      .done_o     (gen_done)
   );

   assign evt_chan_o = CHAN_W'(CHAN_ID);

endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk #(
   parameter int NDESC   = 8,
   parameter int CHAN_ID = 5,
   parameter int CHAN_W  = 6,
   parameter int ADDR_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_reset_i,
   input logic              ram_re_o,
   input logic              ram_we_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [15:0]       ram_wdata_o,
   input logic              tx_valid_o,
   input logic              tx_ready_i,
   input logic [7:0]        tx_data_o,
   input logic              tx_last_o,
   input logic              evt_valid_o,
   input logic [1:0]        evt_code_o,
   input logic [CHAN_W-1:0] evt_chan_o
);
   localparam int LO = CHAN_ID * 2 * NDESC;
   localparam int HI = LO + NDESC - 1;

   a_r3_release_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> !ram_wdata_o[15]);

   a_r4_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re_o || ram_we_o) |-> (ram_addr_o >= ADDR_W'(LO) && ram_addr_o <= ADDR_W'(HI)));

   a_r11_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i && !chan_reset_i) |=>
         (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

   a_r8_event_tagged: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o |-> (evt_chan_o == CHAN_W'(CHAN_ID) && $onehot(evt_code_o)));

   a_r12_reset_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset_i |=> (!tx_valid_o && !ram_re_o && !ram_we_o && !evt_valid_o));

   a_r2_stream_excludes_ram: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> (!ram_re_o && !ram_we_o));

endmodule

bind txd_ring_engine txd_ring_engine_chk #(
   .NDESC(NDESC), .CHAN_ID(CHAN_ID), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_reset_i (chan_reset_i),
   .ram_re_o     (ram_re_o),
   .ram_we_o     (ram_we_o),
   .ram_addr_o   (ram_addr_o),
   .ram_wdata_o  (ram_wdata_o),
   .tx_valid_o   (tx_valid_o),
   .tx_ready_i   (tx_ready_i),
   .tx_data_o    (tx_data_o),
   .tx_last_o    (tx_last_o),
   .evt_valid_o  (evt_valid_o),
   .evt_code_o   (evt_code_o),
   .evt_chan_o   (evt_chan_o)
);

// File: tb/sim_txd_ring_engine.sv
module sim_txd_ring_engine;
   localparam int NDESC   = 8;
   localparam int CHAN_ID = 5;
   localparam int CHAN_W  = 6;
   localparam int ADDR_W  = 10;
   localparam int BASE    = CHAN_ID * 2 * NDESC;

   localparam logic [15:0] F_R  = 16'h8000;
   localparam logic [15:0] F_W  = 16'h2000;
   localparam logic [15:0] F_I  = 16'h1000;
   localparam logic [15:0] F_L  = 16'h0800;
   localparam logic [15:0] F_TC = 16'h0400;
   localparam logic [15:0] F_UB = 16'h0080;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              poll_i = 1'b0;
   logic              en_set_i = 1'b0;
   logic              chan_reset_i = 1'b0;
   logic              ram_re_o, ram_we_o;
   logic [ADDR_W-1:0] ram_addr_o;
   logic [63:0]       ram_rdata_i = '0;
   logic [15:0]       ram_wdata_o;
   logic              tx_valid_o, tx_last_o;
   logic              tx_ready_i = 1'b1;
   logic [7:0]        tx_data_o;
   logic              evt_valid_o;
   logic [1:0]        evt_code_o;
   logic [CHAN_W-1:0] evt_chan_o;

   always #2 clk = ~clk;

   txd_ring_engine #(.NDESC(NDESC), .CHAN_ID(CHAN_ID), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .en_set_i(en_set_i),
      .chan_reset_i(chan_reset_i), .ram_re_o(ram_re_o), .ram_we_o(ram_we_o),
      .ram_addr_o(ram_addr_o), .ram_rdata_i(ram_rdata_i), .ram_wdata_o(ram_wdata_o),
      .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
      .tx_last_o(tx_last_o), .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o),
      .evt_chan_o(evt_chan_o)
   );

   // descriptor RAM model, one cycle read latency
   logic [63:0] mem [0:127];
   always @(posedge clk) begin
      if (ram_re_o) ram_rdata_i <= mem[ram_addr_o[6:0]];
      if (ram_we_o) mem[ram_addr_o[6:0]][63:48] <= ram_wdata_o;
   end

   // stream and event capture
   logic [7:0] cap_d [0:63];
   logic       cap_l [0:63];
   int         cap_n = 0;
   int         txb_n = 0;
   int         un_n = 0;
   int         bad_chan = 0;
   always @(posedge clk) begin
      if (tx_valid_o && tx_ready_i) begin
         if (cap_n < 64) begin
            cap_d[cap_n] = tx_data_o;
            cap_l[cap_n] = tx_last_o;
         end
         cap_n = cap_n + 1;
      end
      if (evt_valid_o) begin
         if (evt_code_o == 2'b01) txb_n = txb_n + 1;
         else if (evt_code_o == 2'b10) un_n = un_n + 1;
         if (evt_chan_o != CHAN_W'(CHAN_ID)) bad_chan = bad_chan + 1;
      end
   end

   // backpressure pattern
   logic bp_mode = 1'b0;
   int   bp_cnt = 0;
   always @(negedge clk) begin
      bp_cnt <= bp_cnt + 1;
      tx_ready_i <= bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
   end

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic [7:0] exp_d [0:63];
   logic       exp_l [0:63];
   int         exp_n = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input int slot, input logic [15:0] st, input logic [15:0] len,
                      input logic [31:0] a);
      mem[BASE + slot] = {st, len, a};
   endtask

   function automatic logic [15:0] status_of(input int slot);
      return mem[BASE + slot][63:48];
   endfunction

   task automatic clear_cap();
      cap_n = 0;
      exp_n = 0;
   endtask

   task automatic add_exp(input logic [31:0] a, input int len, input bit eof);
      for (int k = 0; k < len; k++) begin
         exp_d[exp_n] = a[7:0] + 8'(k);
         exp_l[exp_n] = eof && (k == len - 1);
         exp_n++;
      end
   endtask

   task automatic cmp_stream(input string req);
      chk(cap_n == exp_n, req, "byte count", cap_n, exp_n);
      for (int k = 0; k < exp_n && k < cap_n && k < 64; k++) begin
         chk(cap_d[k] == exp_d[k], req, $sformatf("byte %0d", k), cap_d[k], exp_d[k]);
         chk(cap_l[k] == exp_l[k], "R7", $sformatf("last flag %0d", k), cap_l[k], exp_l[k]);
      end
   endtask

   task automatic pulse_poll();
      @(negedge clk) poll_i = 1'b1;
      @(negedge clk) poll_i = 1'b0;
   endtask

   task automatic pulse_en();
      @(negedge clk) en_set_i = 1'b1;
      @(negedge clk) en_set_i = 1'b0;
   endtask

   task automatic pulse_creset();
      @(negedge clk) chan_reset_i = 1'b1;
      @(negedge clk) chan_reset_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int t0;
      logic [15:0] st0;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      settle(3);
      rst_n = 1'b1;
      settle(2);

      // R1: reset state
      chk(!tx_valid_o && !evt_valid_o, "R1", "idle outputs", {tx_valid_o, evt_valid_o}, 0);
      chk(!ram_re_o && !ram_we_o, "R1", "no ram access", {ram_re_o, ram_we_o}, 0);

      // R2/R12: ready slot and poll, but no enable -> nothing
      st0 = F_R | F_L | F_I | F_TC | F_UB | 16'h0005;
      put(0, st0, 16'd3, 32'h1234_5610);
      pulse_poll();
      settle(40);
      chk(cap_n == 0, "R12", "no send before enable", cap_n, 0);
      chk(status_of(0) == st0, "R2", "slot0 untouched", status_of(0), st0);

      // R2/R3/R7/R8: enable with poll still pending
      clear_cap();
      add_exp(32'h1234_5610, 3, 1'b1);
      pulse_en();
      settle(40);
      cmp_stream("R2");
      chk(status_of(0) == (st0 & 16'h7FFF), "R3", "status write-back", status_of(0), st0 & 16'h7FFF);
      chk(txb_n == 1, "R8", "done event count", txb_n, 1);
      chk(un_n == 0, "R9", "no underrun on closed frame", un_n, 0);
      chk(bad_chan == 0, "R8", "event channel tag", bad_chan, 0);

      // R6: poll self-cleared, ready slot without poll is ignored
      clear_cap();
      put(1, F_R | F_L, 16'd2, 32'h20);
      settle(40);
      chk(cap_n == 0, "R6", "no send without new poll", cap_n, 0);
      add_exp(32'h20, 2, 1'b1);
      pulse_poll();
      settle(40);
      cmp_stream("R6");
      chk(txb_n == 1, "R8", "no event without irq bit", txb_n, 1);

      // R5/R7: two-slot frame chained on one poll
      clear_cap();
      put(2, F_R, 16'd2, 32'h30);
      put(3, F_R | F_L | F_I, 16'd3, 32'h40);
      add_exp(32'h30, 2, 1'b0);
      add_exp(32'h40, 3, 1'b1);
      pulse_poll();
      settle(50);
      cmp_stream("R5");
      chk(txb_n == 2, "R8", "done event after frame", txb_n, 2);
      chk(un_n == 0, "R9", "no underrun", un_n, 0);

      // R9: open frame meets empty slot
      clear_cap();
      put(4, F_R, 16'd1, 32'h50);
      add_exp(32'h50, 1, 1'b0);
      pulse_poll();
      settle(40);
      cmp_stream("R9");
      chk(un_n == 1, "R9", "underrun event", un_n, 1);
      pulse_poll();
      settle(30);
      chk(un_n == 1, "R9", "underrun reported once", un_n, 1);

      // R4: wrap bit returns to slot 0, slot 6 skipped
      clear_cap();
      put(5, F_R | F_W | F_L, 16'd1, 32'h60);
      put(6, F_R | F_L, 16'd1, 32'h70);
      add_exp(32'h60, 1, 1'b1);
      pulse_poll();
      settle(40);
      cmp_stream("R4");
      clear_cap();
      put(0, F_R | F_L, 16'd1, 32'h80);
      add_exp(32'h80, 1, 1'b1);
      pulse_poll();
      settle(40);
      cmp_stream("R4");
      chk(status_of(6)[15] == 1'b1, "R4", "slot6 left ready", status_of(6)[15], 1);

      // R10: zero-length descriptor
      clear_cap();
      t0 = txb_n;
      put(1, F_R | F_L | F_I, 16'd0, 32'h90);
      pulse_poll();
      settle(40);
      chk(cap_n == 0, "R10", "no bytes", cap_n, 0);
      chk(txb_n == t0 + 1, "R10", "done event", txb_n, t0 + 1);
      chk(status_of(1) == (F_L | F_I), "R10", "released", status_of(1), F_L | F_I);

      // R11: backpressure, byte value wraps past 0xFF
      clear_cap();
      bp_mode = 1'b1;
      put(2, F_R | F_L | F_I, 16'd6, 32'hFC);
      add_exp(32'hFC, 6, 1'b1);
      pulse_poll();
      settle(80);
      cmp_stream("R11");
      bp_mode = 1'b0;
      settle(3);

      // R12: channel reset mid-stream, then enable and poll both needed
      put(3, F_R | F_L, 16'd200, 32'h0);
      pulse_poll();
      settle(10);
      chk(tx_valid_o == 1'b1, "R12", "stream running", tx_valid_o, 1);
      pulse_creset();
      settle(2);
      clear_cap();
      settle(20);
      chk(cap_n == 0, "R12", "stream aborted", cap_n, 0);
      put(0, F_R | F_L, 16'd1, 32'hA0);
      pulse_poll();
      settle(30);
      chk(cap_n == 0, "R12", "enable cleared", cap_n, 0);
      add_exp(32'hA0, 1, 1'b1);
      pulse_en();
      settle(30);
      cmp_stream("R12");

      // R4/R5 sweep: all slots, slot 7 without wrap bit
      pulse_creset();
      clear_cap();
      t0 = txb_n;
      for (int s = 0; s < NDESC; s++) begin
         put(s, F_R | F_L | F_I, 16'(s + 1), 32'(s * 16 + 3));
         add_exp(32'(s * 16 + 3), s + 1, 1'b1);
      end
      pulse_en();
      pulse_poll();
      settle(200);
      cmp_stream("R5");
      chk(txb_n == t0 + NDESC, "R8", "sweep events", txb_n, t0 + NDESC);
      for (int s = 0; s < NDESC; s++)
         chk(status_of(s)[15] == 1'b0, "R3", $sformatf("sweep slot %0d released", s), status_of(s)[15], 0);
      clear_cap();
      put(0, F_R | F_L, 16'd1, 32'hEE);
      add_exp(32'hEE, 1, 1'b1);
      pulse_poll();
      settle(30);
      cmp_stream("R4");
      chk(bad_chan == 0, "R8", "event channel tag", bad_chan, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule